// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Interpreter

This block is the serial front end of a dual-channel digital potentiometer and comparator controller. It listens on a two-wire bus as a slave. Both bus lines are oversampled in the system clock domain. The block finds start and stop conditions and matches an identification byte. It then decodes an instruction byte and turns the bus traffic into single-cycle command strobes for the register bank next to it. When it acknowledges or returns read data, it pulls the data line low through an open-drain enable, `sda_oe`.

There are three kinds of command. A transfer command is complete after two acknowledged bytes. A read or write command adds a third byte that carries a six-bit value. The step command puts the block into a continuous mode: every later SCL pulse moves the selected wiper by one step, upward if SDA is high and downward if SDA is low, until a stop condition arrives.

The controller states are IDLE, ADDR, ADDR_ACK, INSTR, INSTR_ACK, WDATA, WDATA_ACK, RDATA, RDATA_ACK and STEP. The transitions are as follows:
- A start condition moves the block from any state to ADDR. A stop condition moves it from any state to IDLE.
- ADDR goes to ADDR_ACK on a matching identification byte and to IDLE otherwise.
- ADDR_ACK goes to INSTR.
- INSTR goes to INSTR_ACK on a known opcode and to IDLE otherwise.
- INSTR_ACK goes to WDATA for writes, RDATA for reads, STEP for the step command and IDLE for transfers.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes to IDLE.
- RDATA goes to RDATA_ACK, and RDATA_ACK goes to IDLE.
- STEP stays in STEP until a start or stop.

Top module: `pot_cmd_if`

## Requirements
- R1: Bytes are sent MSB first, with SDA sampled on the rising edge of SCL. The identification byte is 4'b0101 in bits 7..4 and `dev_addr` in bits 3..0. The block pulls SDA low in the ninth clock only when both parts match. Otherwise it does not acknowledge, and it ignores all traffic until the next start.
- R2: In the instruction byte, bits 7..4 are the opcode, bits 3..2 are the pot select and bits 1..0 are the register select. On a known opcode the block acknowledges and presents the pot select on `sel_pot` and the register select on `sel_reg`.
- R3: Any opcode outside the table below gets no acknowledge. The block returns to IDLE and emits no strobe for the bytes that follow.
- R4: Transfer opcode 4'b1101 (data register to wiper) emits `op_code` 3. Transfer opcode 4'b1110 (wiper to data register) emits `op_code` 4. Each strobe is issued when the instruction byte is acknowledged, with `op_data` equal to 0.
- R5: Write opcodes are 4'b1010 (wiper, `op_code` 1) and 4'b1100 (data register, `op_code` 2). These take a third byte, which the block acknowledges. The strobe carries bits 5..0 of that byte on `op_data`, and bits 7..6 are ignored.
- R6: Read opcodes are 4'b1001 (wiper, `rd_data_sel`=0) and 4'b1011 (data register, `rd_data_sel`=1). The block returns one byte made of two zero bits followed by `rd_data`, with each bit changing after a falling edge of SCL.
- R7: Opcode 4'b0010 enters step mode. Each complete SCL high pulse then emits one strobe when SCL falls. The strobe is `op_code` 5 (step up) if SDA was high at the rising edge and `op_code` 6 (step down) if SDA was low.
- R8: A stop condition ends step mode. The unfinished SCL pulse that carries the stop gives no step, and later SCL pulses give no step.
- R9: A start condition in any state abandons the command in progress without a strobe and restarts identification matching.
- R10: After reset, `sda_oe` and `op_stb` are low and the block is in IDLE.
- R11: Each command gives exactly one `op_stb` pulse, and each pulse lasts one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| dev_addr | input | 4 | Device address strap |
| rd_data | input | DATA_W | Value of the selected register, for reads |
| sda_oe | output | 1 | 1 pulls the data line low |
| op_stb | output | 1 | One-cycle command strobe |
| op_code | output | 3 | Command code qualified by `op_stb` |
| op_data | output | DATA_W | Write data qualified by `op_stb` |
| sel_pot | output | 2 | Selected potentiometer |
| sel_reg | output | 2 | Selected register |
| rd_data_sel | output | 1 | 1 selects the data register for reads, 0 selects the wiper |

## Verification
A corrupted state or bit count shows up first in the acknowledge slot. The data line is released or pulled in the wrong ninth clock, and this is visible within one SCL period of the faulty byte. An error in command decoding shows up on the strobe that ends that command: the code, the data or the pulse count is wrong. A step-mode fault shows up on the step-up and step-down totals by the next SCL falling edge. A lost stop or start shows up in the response to the very next byte.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

    localparam int BYTE_W = 8;

    // Instruction opcodes (bits 7..4 of the instruction byte)
    localparam logic [3:0] OPC_RD_WIPER   = 4'b1001;
    localparam logic [3:0] OPC_WR_WIPER   = 4'b1010;
    localparam logic [3:0] OPC_RD_DATA    = 4'b1011;
    localparam logic [3:0] OPC_WR_DATA    = 4'b1100;
    localparam logic [3:0] OPC_LOAD_WIPER = 4'b1101;
    localparam logic [3:0] OPC_SAVE_WIPER = 4'b1110;
    localparam logic [3:0] OPC_STEP       = 4'b0010;

    // Codes presented on op_code
    localparam logic [2:0] OUT_WR_WIPER   = 3'd1;
    localparam logic [2:0] OUT_WR_DATA    = 3'd2;
    localparam logic [2:0] OUT_LOAD_WIPER = 3'd3;
    localparam logic [2:0] OUT_SAVE_WIPER = 3'd4;
    localparam logic [2:0] OUT_STEP_UP    = 3'd5;
    localparam logic [2:0] OUT_STEP_DN    = 3'd6;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_RD_WIPER, CMD_WR_WIPER, CMD_RD_DATA,
        CMD_WR_DATA, CMD_LOAD_WIPER, CMD_SAVE_WIPER, CMD_STEP
    } cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_STEP
    } state_t;

    function automatic cmd_t decode_op(input logic [3:0] opc);
        case (opc)
            OPC_RD_WIPER:   return CMD_RD_WIPER;
            OPC_WR_WIPER:   return CMD_WR_WIPER;
            OPC_RD_DATA:    return CMD_RD_DATA;
            OPC_WR_DATA:    return CMD_WR_DATA;
            OPC_LOAD_WIPER: return CMD_LOAD_WIPER;
            OPC_SAVE_WIPER: return CMD_SAVE_WIPER;
            OPC_STEP:       return CMD_STEP;
            default:        return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] sync_v;
    logic [LINES-1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[l]};
        end
        assign sync_v[l] = pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= sync_v;
    end

    assign sda_s     = sync_v[1];
    assign scl_rise  = sync_v[0] & ~prev[0];
    assign scl_fall  = ~sync_v[0] & prev[0];
    assign start_det = sync_v[0] & prev[0] & prev[1] & ~sync_v[1];
    assign stop_det  = sync_v[0] & prev[0] & ~prev[1] & sync_v[1];

endmodule

// File: rtl/twi_bit_shift.sv
module twi_bit_shift #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          shin,
    input  logic          shout,
    input  logic          din,
    output logic [W-1:0]  q,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            q   <= load_val;
            cnt <= '0;
        end else if (shin) begin
            q   <= {q[W-2:0], din};
            cnt <= cnt + 1'b1;
        end else if (shout) begin
            q   <= {q[W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pot_cmd_if.sv
module pot_cmd_if
    import pot_cmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         DATA_W      = 6,
    parameter logic [3:0] ID_CODE     = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [3:0]        dev_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              op_stb,
    output logic [2:0]        op_code,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        sel_pot,
    output logic [1:0]        sel_reg,
    output logic              rd_data_sel
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic sh_clr, sh_load, sh_in, sh_out;
    logic [BYTE_W-1:0] q, ldval;
    logic [CNT_W-1:0]  cnt;
    logic cnt_full, cnt_last;

    state_t st, st_n;
    cmd_t   cmd_q, cmd_n, dec;
    logic   oe_n, stb_n, dir_q, dir_n, arm_q, arm_n;
    logic [2:0]        code_n;
    logic [DATA_W-1:0] data_n;
    logic [1:0]        pot_n, reg_n;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_bit_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load),
        .load_val(ldval), .shin(sh_in), .shout(sh_out), .din(sda_s),
        .q(q), .cnt(cnt)
    );

    assign ldval    = BYTE_W'(rd_data);
    assign cnt_full = (cnt == CNT_W'(BYTE_W));
    assign cnt_last = (cnt == CNT_W'(BYTE_W - 1));
    assign dec      = decode_op(q[7:4]);
    assign rd_data_sel = (cmd_q == CMD_RD_DATA);

    // State and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cmd_q   <= CMD_NONE;
            sda_oe  <= 1'b0;
            op_stb  <= 1'b0;
            op_code <= '0;
            op_data <= '0;
            sel_pot <= '0;
            sel_reg <= '0;
            dir_q   <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            st      <= st_n;
            cmd_q   <= cmd_n;
            sda_oe  <= oe_n;
            op_stb  <= stb_n;
            op_code <= code_n;
            op_data <= data_n;
            sel_pot <= pot_n;
            sel_reg <= reg_n;
            dir_q   <= dir_n;
            arm_q   <= arm_n;
        end
    end

    // Next state and next outputs
    always_comb begin
        st_n = st;   cmd_n = cmd_q; oe_n = sda_oe; stb_n = 1'b0;
        code_n = op_code; data_n = op_data;
        pot_n = sel_pot;  reg_n = sel_reg;
        dir_n = dir_q;    arm_n = arm_q;
        sh_clr = 1'b0; sh_load = 1'b0; sh_in = 1'b0; sh_out = 1'b0;
        if (start_det) begin
            st_n = ST_ADDR; sh_clr = 1'b1; oe_n = 1'b0; arm_n = 1'b0;
        end else if (stop_det) begin
            st_n = ST_IDLE; oe_n = 1'b0; arm_n = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && !cnt_full) sh_in = 1'b1;
                    else if (scl_fall && cnt_full) begin
                        if (q == {ID_CODE, dev_addr}) begin
                            oe_n = 1'b1; st_n = ST_ADDR_ACK;
                        end else st_n = ST_IDLE;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    oe_n = 1'b0; sh_clr = 1'b1; st_n = ST_INSTR;
                end
                ST_INSTR: begin
                    if (scl_rise && !cnt_full) sh_in = 1'b1;
                    else if (scl_fall && cnt_full) begin
                        if (dec == CMD_NONE) st_n = ST_IDLE;
                        else begin
                            oe_n = 1'b1; st_n = ST_INSTR_ACK; cmd_n = dec;
                            pot_n = q[3:2]; reg_n = q[1:0];
                            if (dec == CMD_LOAD_WIPER || dec == CMD_SAVE_WIPER) begin
                                stb_n  = 1'b1; data_n = '0;
                                code_n = (dec == CMD_LOAD_WIPER) ? OUT_LOAD_WIPER
                                                                 : OUT_SAVE_WIPER;
                            end
                        end
                    end
                end
                ST_INSTR_ACK: if (scl_fall) begin
                    sh_clr = 1'b1;
                    case (cmd_q)
                        CMD_RD_WIPER, CMD_RD_DATA: begin
                            sh_clr = 1'b0; sh_load = 1'b1;
                            oe_n = ~ldval[BYTE_W-1]; st_n = ST_RDATA;
                        end
                        CMD_WR_WIPER, CMD_WR_DATA: begin
                            oe_n = 1'b0; st_n = ST_WDATA;
                        end
                        CMD_STEP: begin
                            oe_n = 1'b0; st_n = ST_STEP; arm_n = 1'b0;
                        end
                        default: begin
                            oe_n = 1'b0; st_n = ST_IDLE;
                        end
                    endcase
                end
                ST_WDATA: begin
                    if (scl_rise && !cnt_full) sh_in = 1'b1;
                    else if (scl_fall && cnt_full) begin
                        oe_n = 1'b1; stb_n = 1'b1; st_n = ST_WDATA_ACK;
                        data_n = q[DATA_W-1:0];
                        code_n = (cmd_q == CMD_WR_WIPER) ? OUT_WR_WIPER : OUT_WR_DATA;
                    end
                end
                ST_WDATA_ACK: if (scl_fall) begin
                    oe_n = 1'b0; st_n = ST_IDLE;
                end
                ST_RDATA: if (scl_fall) begin
                    if (cnt_last) begin
                        oe_n = 1'b0; st_n = ST_RDATA_ACK;
                    end else begin
                        sh_out = 1'b1; oe_n = ~q[BYTE_W-2];
                    end
                end
                ST_RDATA_ACK: if (scl_fall) st_n = ST_IDLE;
                ST_STEP: begin
                    if (scl_rise) begin
                        dir_n = sda_s; arm_n = 1'b1;
                    end else if (scl_fall && arm_q) begin
                        stb_n = 1'b1; arm_n = 1'b0; data_n = '0;
                        code_n = dir_q ? OUT_STEP_UP : OUT_STEP_DN;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // R11
    op_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_stb |=> !op_stb);

    // R8
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE) && !sda_oe);

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR) && !sda_oe);

    // R7
    step_only_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && (op_code == OUT_STEP_UP || op_code == OUT_STEP_DN)) |-> (st == ST_STEP));

    // R1
    oe_rise_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (st inside {ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK, ST_RDATA}));

endmodule

// File: tb/pot_cmd_if_test.sv
`timescale 1ns/1ps
module pot_cmd_if_test;
    localparam int H = 8;
    localparam logic [3:0] ADDR = 4'hA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [5:0] rd_data = '0;
    logic sda_oe, op_stb, rd_data_sel;
    logic [2:0] op_code;
    logic [5:0] op_data;
    logic [1:0] sel_pot, sel_reg;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_bad = 0, n_stb = 0, n_up = 0, n_dn = 0;
    logic [2:0] last_code = '0;
    logic [5:0] last_data = '0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pot_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .dev_addr(ADDR), .rd_data(rd_data), .sda_oe(sda_oe), .op_stb(op_stb),
        .op_code(op_code), .op_data(op_data), .sel_pot(sel_pot),
        .sel_reg(sel_reg), .rd_data_sel(rd_data_sel)
    );

    always @(negedge clk) if (op_stb) begin
        n_stb++; last_code = op_code; last_data = op_data;
        if (op_code == 3'd5) n_up++;
        if (op_code == 3'd6) n_dn++;
    end

    // op field [25:22], pot [21:20], reg [19:18], data byte [17:10],
    // expected code [9:7], expected data [6:1], three-byte flag [0]
    localparam logic [25:0] VEC [6] = '{
        {4'b1010, 2'd1, 2'd0, 8'hFF, 3'd1, 6'h3F, 1'b1},
        {4'b1010, 2'd2, 2'd3, 8'h15, 3'd1, 6'h15, 1'b1},
        {4'b1100, 2'd3, 2'd2, 8'hC0, 3'd2, 6'h00, 1'b1},
        {4'b1100, 2'd0, 2'd1, 8'h6A, 3'd2, 6'h2A, 1'b1},
        {4'b1101, 2'd1, 2'd2, 8'h00, 3'd3, 6'h00, 1'b0},
        {4'b1110, 2'd2, 2'd1, 8'h00, 3'd4, 6'h00, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(2); scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
        ack = sda_oe; wt(H/2); scl_m = 1'b0; wt(2);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
            d = {d[6:0], sda_line}; wt(H/2); scl_m = 1'b0; wt(2);
        end
        send_bit(!mack);
    endtask

    task automatic head(input logic [7:0] instr, output logic a1, output logic a2);
        bus_start();
        send_byte({4'b0101, ADDR}, a1);
        send_byte(instr, a2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a1, a2, a3;
        logic [7:0] rb;
        int base, bu, bd;
        wt(5);
        // R10 reset state
        chk("R10", "sda_oe in reset", 32'(sda_oe), 0);
        chk("R10", "op_stb in reset", 32'(op_stb), 0);
        rst_n = 1'b1; wt(H);
        chk("R10", "sda_oe after reset", 32'(sda_oe), 0);
        chk("R10", "no strobe after reset", 32'(n_stb), 0);

        // R2 R4 R5 R11 table of commands
        foreach (VEC[k]) begin
            logic [25:0] v;
            v = VEC[k];
            base = n_stb;
            head({v[25:22], v[21:20], v[19:18]}, a1, a2);
            chk("R1", "id ack", 32'(a1), 1);
            chk("R2", "instr ack", 32'(a2), 1);
            chk("R2", "sel_pot", 32'(sel_pot), 32'(v[21:20]));
            chk("R2", "sel_reg", 32'(sel_reg), 32'(v[19:18]));
            if (v[0]) begin
                send_byte(v[17:10], a3);
                chk("R5", "data ack", 32'(a3), 1);
            end
            bus_stop();
            chk("R11", "one strobe", 32'(n_stb - base), 1);
            chk(v[0] ? "R5" : "R4", "op_code", 32'(last_code), 32'(v[9:7]));
            chk(v[0] ? "R5" : "R4", "op_data", 32'(last_data), 32'(v[6:1]));
        end

        // R1 wrong device address, later bytes ignored
        base = n_stb;
        bus_start();
        send_byte({4'b0101, 4'h3}, a1);
        chk("R1", "wrong address nack", 32'(a1), 0);
        send_byte(8'hA4, a2);
        chk("R1", "ignored after nack", 32'(a2), 0);
        bus_stop();
        bus_start();
        send_byte({4'b0110, ADDR}, a1);
        chk("R1", "wrong id code nack", 32'(a1), 0);
        bus_stop();
        chk("R1", "no strobe after nack", 32'(n_stb - base), 0);

        // R3 unknown opcode
        head({4'b0111, 2'd1, 2'd1}, a1, a2);
        chk("R3", "unknown opcode nack", 32'(a2), 0);
        send_byte(8'h2A, a3);
        chk("R3", "following byte nack", 32'(a3), 0);
        bus_stop();
        chk("R3", "no strobe", 32'(n_stb - base), 0);

        // R6 reads
        rd_data = 6'h2B;
        head({4'b1001, 2'd2, 2'd1}, a1, a2);
        chk("R6", "read ack", 32'(a2), 1);
        chk("R6", "wiper source", 32'(rd_data_sel), 0);
        recv_byte(rb, 1'b0);
        bus_stop();
        chk("R6", "wiper read byte", 32'(rb), 32'h2B);
        rd_data = 6'h3F;
        head({4'b1011, 2'd1, 2'd3}, a1, a2);
        chk("R6", "data source", 32'(rd_data_sel), 1);
        recv_byte(rb, 1'b0);
        bus_stop();
        chk("R6", "data read byte with zero top bits", 32'(rb), 32'h3F);
        chk("R6", "read makes no strobe", 32'(n_stb - base), 0);

        // R7 step mode
        bu = n_up; bd = n_dn;
        head({4'b0010, 2'd3, 2'd0}, a1, a2);
        chk("R7", "step ack", 32'(a2), 1);
        chk("R7", "step pot", 32'(sel_pot), 3);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        wt(H);
        chk("R7", "step up count", 32'(n_up - bu), 3);
        chk("R7", "step down count", 32'(n_dn - bd), 2);
        chk("R7", "last step down", 32'(last_code), 6);
        // R8 stop ends step mode with no extra step
        bus_stop();
        chk("R8", "stop pulse no step", 32'(n_up + n_dn - bu - bd), 5);
        scl_m = 1'b0; wt(2);
        send_bit(1'b1); send_bit(1'b0); wt(H);
        chk("R8", "no step after stop", 32'(n_up + n_dn - bu - bd), 5);

        // R9 start aborts a write midway
        base = n_stb;
        head({4'b1010, 2'd0, 2'd2}, a1, a2);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        head({4'b1100, 2'd1, 2'd0}, a1, a2);
        chk("R9", "restart id ack", 32'(a1), 1);
        send_byte(8'h0C, a3);
        bus_stop();
        chk("R9", "only one strobe", 32'(n_stb - base), 1);
        chk("R9", "restarted command code", 32'(last_code), 2);
        chk("R9", "restarted command data", 32'(last_data), 32'h0C);

        // R9 start leaves step mode
        base = n_stb;
        head({4'b0010, 2'd1, 2'd0}, a1, a2);
        send_bit(1'b1);
        head({4'b1101, 2'd2, 2'd2}, a1, a2);
        bus_stop();
        chk("R9", "step then restart strobes", 32'(n_stb - base), 2);
        chk("R9", "restart transfer code", 32'(last_code), 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule